// File: doc/BRIEF.md
# Bitmask Slot Packet Scheduler

This block builds one radio payload per frame out of a set of configurable data slots. Each slot holds a data length of 0 to 15 bytes, a 32-bit schedule mask and up to 15 stored data bytes, all loaded through a small write port. When a frame-start pulse arrives, the block uses the low bits of its frame counter to look up one bit in every slot's mask. It then emits each due slot, in ascending slot order, as a header byte followed by that slot's data bytes.

The output is a byte stream with valid, ready and last. One cycle after an accepted frame start, a one-cycle length strobe reports the byte count of the frame that is about to stream. A due slot that would push the payload past the maximum size is dropped for that frame and the overflow flag is raised. Slots after it are still tried. Choosing masks and sizes so that frames fit is the host's job. The flag only reports when it was not done.

Top module: `slot_pkt_sched`

## Requirements
- R1: Each emitted slot begins with a header byte. Bits [7:4] hold the slot number and bits [3:0] hold its data length. The slot's data bytes follow, starting with byte index 0 and in increasing index order.
- R2: Take f as the frame-counter value at an accepted frame start. A slot is due in frame f when its length is nonzero and mask bit (31 - (f mod 32)) is set. All ones gives every frame, 0xAAAAAAAA gives even frames, 0x55555555 gives odd frames and 0x11111111 gives frames 3, 7, 11 and so on.
- R3: Due slots are emitted in ascending slot number.
- R4: A slot with length 0 or an all-zero mask emits nothing, not even a header.
- R5: Due slots are tried in ascending order. A slot whose header plus data would push the running total past 32 bytes is skipped and overflow_o is set. Later slots are still tried. overflow_o holds its value until the next accepted frame start.
- R6: The frame counter resets to 0 and increments by one on each accepted frame start. A frame start that arrives while tx_valid_o is high is ignored.
- R7: len_valid_o is high for exactly the cycle after an accepted frame start, with frame_len_o equal to the frame's byte count. A count of 0 produces no bytes and tx_valid_o stays low.
- R8: tx_last_o is high only on the final byte of a frame, and the number of bytes transferred equals frame_len_o.
- R9: While tx_valid_o is high and tx_ready_i is low, tx_data_o and tx_last_o stay unchanged in the next cycle.
- R10: The write port is selected by wr_sel_i. The value 0 writes the length from wr_data_i[3:0]. The value 1 writes the mask from wr_data_i[31:0]. The value 2 writes data byte wr_idx_i from wr_data_i[7:0]. All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_sel_i | input | 2 | Write target: 0 length, 1 mask, 2 data byte |
| wr_slot_i | input | 4 | Slot number to write |
| wr_idx_i | input | 4 | Data byte index for data writes |
| wr_data_i | input | 32 | Write value |
| frame_start_i | input | 1 | Frame start pulse |
| tx_data_o | output | 8 | Stream byte |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_ready_i | input | 1 | Stream sink ready |
| tx_last_o | output | 1 | Final byte of the frame |
| frame_len_o | output | 6 | Byte count of the current frame |
| len_valid_o | output | 1 | frame_len_o strobe, one cycle |
| overflow_o | output | 1 | A due slot was dropped in the current frame |
| frame_cnt_o | output | 32 | Frame counter |

## Verification
The bench builds the block with six slots and keeps the default 32-bit mask and 32-byte payload limit. That is enough for the four-slot example pattern, plus a zero-length slot and a zero-mask slot, to be swept over 64 consecutive frames. The sweep covers every mask phase twice, including the wrap of the phase. A second set of lengths forces a skipped slot in the middle with a later slot that still fits, so the frame lands exactly on the 32-byte limit. A zero-mask configuration produces the empty-frame strobe, and a frame start sent in the middle of a stalled frame checks that such a start is ignored.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
  localparam int ID_W   = 4;
  localparam int LEN_W  = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    WR_LEN  = 2'd0,
    WR_MASK = 2'd1,
    WR_DATA = 2'd2
  } wr_sel_e;
endpackage

// File: rtl/slot_store.sv
module slot_store
  import slot_sched_pkg::*;
#(
  parameter int NUM_SLOTS = 15,
  parameter int MASK_W    = 32
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_en_i,
  input  logic [1:0]                          wr_sel_i,
  input  logic [ID_W-1:0]                     wr_slot_i,
  input  logic [LEN_W-1:0]                    wr_idx_i,
  input  logic [MASK_W-1:0]                   wr_data_i,
  input  logic [ID_W-1:0]                     rd_slot_i,
  input  logic [LEN_W-1:0]                    rd_idx_i,
  output logic [BYTE_W-1:0]                   rd_byte_o,
  output logic [NUM_SLOTS-1:0][LEN_W-1:0]     len_o,
  output logic [NUM_SLOTS-1:0][MASK_W-1:0]    mask_o
);
  localparam int MAX_LEN = (1 << LEN_W) - 1;

  logic [BYTE_W-1:0] data_q [NUM_SLOTS][MAX_LEN];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic hit;
    assign hit = wr_en_i && (wr_slot_i == ID_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        len_o[s]  <= '0;
        mask_o[s] <= '0;
      end else if (hit) begin
        if (wr_sel_i == WR_LEN)  len_o[s]  <= wr_data_i[LEN_W-1:0];
        if (wr_sel_i == WR_MASK) mask_o[s] <= wr_data_i;
      end
    end

    for (genvar b = 0; b < MAX_LEN; b++) begin : g_byte
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          data_q[s][b] <= '0;
        end else if (hit && wr_sel_i == WR_DATA && wr_idx_i == LEN_W'(b)) begin
          data_q[s][b] <= wr_data_i[BYTE_W-1:0];
        end
      end
    end
  end

  always_comb begin
    rd_byte_o = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      for (int b = 0; b < MAX_LEN; b++) begin
        if (rd_slot_i == ID_W'(s) && rd_idx_i == LEN_W'(b)) rd_byte_o = data_q[s][b];
      end
    end
  end
endmodule

// File: rtl/frame_planner.sv
module frame_planner
  import slot_sched_pkg::*;
#(
  parameter int NUM_SLOTS   = 15,
  parameter int MASK_W      = 32,
  parameter int PAYLOAD_MAX = 32,
  localparam int PH_W = $clog2(MASK_W),
  localparam int FL_W = $clog2(PAYLOAD_MAX + 1)
) (
  input  logic [PH_W-1:0]                  phase_i,
  input  logic [NUM_SLOTS-1:0][LEN_W-1:0]  len_i,
  input  logic [NUM_SLOTS-1:0][MASK_W-1:0] mask_i,
  output logic [NUM_SLOTS-1:0]             take_o,
  output logic [FL_W-1:0]                  total_o,
  output logic                             ovf_o
);
  localparam int MAX_LEN = (1 << LEN_W) - 1;
  localparam int SUM_W   = $clog2(PAYLOAD_MAX + MAX_LEN + 2);
  localparam logic [PH_W-1:0] TOP_BIT = PH_W'(MASK_W - 1);

  logic [PH_W-1:0]      bit_sel;
  logic [SUM_W-1:0]     acc [NUM_SLOTS+1];
  logic [NUM_SLOTS-1:0] skip;

  // mask is read from its msb down as frames advance
  assign bit_sel = TOP_BIT - phase_i;
  assign acc[0]  = '0;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chain
    logic             due;
    logic [SUM_W-1:0] need;
    assign due       = (len_i[s] != '0) && mask_i[s][bit_sel];
    assign need      = acc[s] + SUM_W'(len_i[s]) + SUM_W'(1);
    assign take_o[s] = due && (need <= SUM_W'(PAYLOAD_MAX));
    assign skip[s]   = due && !take_o[s];
    assign acc[s+1]  = take_o[s] ? need : acc[s];
  end

  assign total_o = acc[NUM_SLOTS][FL_W-1:0];
  assign ovf_o   = |skip;
endmodule

// File: rtl/byte_emitter.sv
module byte_emitter
  import slot_sched_pkg::*;
#(
  parameter int NUM_SLOTS   = 15,
  parameter int PAYLOAD_MAX = 32,
  localparam int FL_W = $clog2(PAYLOAD_MAX + 1)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            load_i,
  input  logic [NUM_SLOTS-1:0]            take_i,
  input  logic [FL_W-1:0]                 total_i,
  input  logic [NUM_SLOTS-1:0][LEN_W-1:0] len_i,
  input  logic [BYTE_W-1:0]               rd_byte_i,
  output logic [ID_W-1:0]                 rd_slot_o,
  output logic [LEN_W-1:0]                rd_idx_o,
  output logic [BYTE_W-1:0]               data_o,
  output logic                            valid_o,
  output logic                            last_o,
  input  logic                            ready_i
);
  logic [NUM_SLOTS-1:0] sel_q;
  logic [FL_W-1:0]      rem_q;
  logic [LEN_W-1:0]     idx_q;
  logic                 hdr_q;
  logic [ID_W-1:0]      cur;
  logic [LEN_W-1:0]     cur_len;
  logic                 fire;

  // lowest pending slot goes first
  always_comb begin
    cur = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (sel_q[s]) cur = ID_W'(s);
    end
  end

  always_comb begin
    cur_len = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (cur == ID_W'(s)) cur_len = len_i[s];
    end
  end

  assign rd_slot_o = cur;
  assign rd_idx_o  = idx_q;
  assign valid_o   = (rem_q != '0);
  assign last_o    = (rem_q == FL_W'(1));
  assign data_o    = hdr_q ? {cur, cur_len} : rd_byte_i;
  assign fire      = valid_o && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      rem_q <= '0;
      idx_q <= '0;
      hdr_q <= 1'b1;
    end else if (load_i) begin
      sel_q <= take_i;
      rem_q <= total_i;
      idx_q <= '0;
      hdr_q <= 1'b1;
    end else if (fire) begin
      rem_q <= rem_q - FL_W'(1);
      if (hdr_q) begin
        hdr_q <= 1'b0;
        idx_q <= '0;
      end else if (idx_q == cur_len - LEN_W'(1)) begin
        sel_q[cur] <= 1'b0;
        hdr_q      <= 1'b1;
        idx_q      <= '0;
      end else begin
        idx_q <= idx_q + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/slot_pkt_sched.sv
module slot_pkt_sched
  import slot_sched_pkg::*;
#(
  parameter int NUM_SLOTS   = 15,
  parameter int MASK_W      = 32,
  parameter int PAYLOAD_MAX = 32,
  parameter int CNT_W       = 32,
  localparam int FL_W = $clog2(PAYLOAD_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [ID_W-1:0]   wr_slot_i,
  input  logic [LEN_W-1:0]  wr_idx_i,
  input  logic [MASK_W-1:0] wr_data_i,
  input  logic              frame_start_i,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              tx_last_o,
  output logic [FL_W-1:0]   frame_len_o,
  output logic              len_valid_o,
  output logic              overflow_o,
  output logic [CNT_W-1:0]  frame_cnt_o
);
  localparam int PH_W = $clog2(MASK_W);

  logic [NUM_SLOTS-1:0][LEN_W-1:0]  len_w;
  logic [NUM_SLOTS-1:0][MASK_W-1:0] mask_w;
  logic [NUM_SLOTS-1:0]             take_w;
  logic [FL_W-1:0]                  total_w;
  logic                             ovf_w;
  logic [ID_W-1:0]                  rd_slot_w;
  logic [LEN_W-1:0]                 rd_idx_w;
  logic [BYTE_W-1:0]                rd_byte_w;
  logic                             accept;

  assign accept = frame_start_i && !tx_valid_o;

  slot_store #(.NUM_SLOTS(NUM_SLOTS), .MASK_W(MASK_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_slot_i (wr_slot_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .rd_slot_i (rd_slot_w),
    .rd_idx_i  (rd_idx_w),
    .rd_byte_o (rd_byte_w),
    .len_o     (len_w),
    .mask_o    (mask_w)
  );

  frame_planner #(
    .NUM_SLOTS(NUM_SLOTS), .MASK_W(MASK_W), .PAYLOAD_MAX(PAYLOAD_MAX)
  ) u_plan (
    .phase_i (frame_cnt_o[PH_W-1:0]),
    .len_i   (len_w),
    .mask_i  (mask_w),
    .take_o  (take_w),
    .total_o (total_w),
    .ovf_o   (ovf_w)
  );

  byte_emitter #(.NUM_SLOTS(NUM_SLOTS), .PAYLOAD_MAX(PAYLOAD_MAX)) u_emit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .take_i    (take_w),
    .total_i   (total_w),
    .len_i     (len_w),
    .rd_byte_i (rd_byte_w),
    .rd_slot_o (rd_slot_w),
    .rd_idx_o  (rd_idx_w),
    .data_o    (tx_data_o),
    .valid_o   (tx_valid_o),
    .last_o    (tx_last_o),
    .ready_i   (tx_ready_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_cnt_o <= '0;
      frame_len_o <= '0;
      len_valid_o <= 1'b0;
      overflow_o  <= 1'b0;
    end else begin
      len_valid_o <= accept;
      if (accept) begin
        frame_cnt_o <= frame_cnt_o + CNT_W'(1);
        frame_len_o <= total_w;
        overflow_o  <= ovf_w;
      end
    end
  end
endmodule

// File: rtl/slot_pkt_sched_chk.sv
module slot_pkt_sched_chk #(
  parameter int PAYLOAD_MAX = 32,
  parameter int CNT_W       = 32,
  localparam int FL_W = $clog2(PAYLOAD_MAX + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_start_i,
  input logic [7:0]       tx_data_o,
  input logic             tx_valid_o,
  input logic             tx_ready_i,
  input logic             tx_last_o,
  input logic [FL_W-1:0]  frame_len_o,
  input logic             len_valid_o,
  input logic             overflow_o,
  input logic [CNT_W-1:0] frame_cnt_o
);
  logic [FL_W-1:0] nb_q, lat_q, nb_now, lat_now;
  logic            fire;

  assign fire    = tx_valid_o && tx_ready_i;
  assign nb_now  = len_valid_o ? '0 : nb_q;
  assign lat_now = len_valid_o ? frame_len_o : lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nb_q  <= '0;
      lat_q <= '0;
    end else begin
      lat_q <= lat_now;
      nb_q  <= fire ? nb_now + FL_W'(1) : nb_now;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));

  // R8
  last_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && tx_last_o |-> (nb_now + FL_W'(1)) == lat_now);

  // R8
  last_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_o |-> tx_valid_o);

  // R6
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && !tx_valid_o |=> frame_cnt_o == $past(frame_cnt_o) + CNT_W'(1));

  // R6
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_start_i && !tx_valid_o) |=> $stable(frame_cnt_o) && $stable(overflow_o));

  // R7
  empty_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_valid_o |-> (tx_valid_o == (frame_len_o != '0)));

  // R5
  len_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_valid_o |-> frame_len_o <= FL_W'(PAYLOAD_MAX));
endmodule

bind slot_pkt_sched slot_pkt_sched_chk #(
  .PAYLOAD_MAX(PAYLOAD_MAX), .CNT_W(CNT_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_start_i (frame_start_i),
  .tx_data_o     (tx_data_o),
  .tx_valid_o    (tx_valid_o),
  .tx_ready_i    (tx_ready_i),
  .tx_last_o     (tx_last_o),
  .frame_len_o   (frame_len_o),
  .len_valid_o   (len_valid_o),
  .overflow_o    (overflow_o),
  .frame_cnt_o   (frame_cnt_o)
);

// File: tb/slot_pkt_sched_tb_top.sv
module slot_pkt_sched_tb_top;
  localparam int NS = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = '0;
  logic [3:0]  wr_slot_i = '0;
  logic [3:0]  wr_idx_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        frame_start_i = 1'b0;
  logic        tx_ready_i = 1'b0;
  logic [7:0]  tx_data_o;
  logic        tx_valid_o, tx_last_o, len_valid_o, overflow_o;
  logic [5:0]  frame_len_o;
  logic [31:0] frame_cnt_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int unsigned fexp = 0;

  int          b_len [NS];
  logic [31:0] b_mask [NS];
  logic [7:0]  e_bytes [32];
  int          e_len;
  bit          e_ovf;

  always #2 clk_i = ~clk_i;

  slot_pkt_sched #(.NUM_SLOTS(NS)) dut_i (.*);

  function automatic logic [7:0] dbyte(int s, int i);
    return 8'((s * 16 + i) ^ 8'hA5);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        finish_run();
      end
    end
  end

  // R10: sel 0 length [3:0], 1 mask [31:0], 2 data byte at idx [7:0]
  task automatic wr(input int sel, input int slot, input int idx, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = 2'(sel); wr_slot_i = 4'(slot);
    wr_idx_i = 4'(idx); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic config_slot(input int s, input int len, input logic [31:0] m);
    b_len[s] = len;
    b_mask[s] = m;
    wr(0, s, 0, 32'(len));
    wr(1, s, 0, m);
    for (int i = 0; i < 15; i++) wr(2, s, i, 32'(dbyte(s, i)));
  endtask

  // independent model of R1..R5
  task automatic model(input int unsigned f);
    int acc = 0;
    e_ovf = 1'b0;
    for (int s = 0; s < NS; s++) begin
      if (b_len[s] != 0 && b_mask[s][31 - (f % 32)]) begin
        if (acc + 1 + b_len[s] <= 32) begin
          e_bytes[acc] = 8'((s << 4) | b_len[s]);
          for (int i = 0; i < b_len[s]; i++) e_bytes[acc + 1 + i] = dbyte(s, i);
          acc += 1 + b_len[s];
        end else begin
          e_ovf = 1'b1;
        end
      end
    end
    e_len = acc;
  endtask

  task automatic do_frame(input int rmode, input bit poke);
    int k = 0;
    int step = 0;
    model(fexp);
    chk(frame_cnt_o == fexp, "R6 count", frame_cnt_o, fexp);
    @(negedge clk_i);
    frame_start_i = 1'b1;
    @(negedge clk_i);
    frame_start_i = 1'b0;
    fexp++;
    chk(len_valid_o == 1'b1, "R7 strobe", len_valid_o, 1);
    chk(frame_len_o == 6'(e_len), "R7 length", frame_len_o, e_len);
    chk(overflow_o == e_ovf, "R5 overflow", overflow_o, e_ovf);
    chk(frame_cnt_o == fexp, "R6 step", frame_cnt_o, fexp);
    if (e_len == 0) chk(tx_valid_o == 1'b0, "R7 empty", tx_valid_o, 0);
    while (k < e_len && step < 400) begin
      if (poke && step == 0) begin
        tx_ready_i = 1'b0;
        frame_start_i = 1'b1;
      end else if (poke && step == 1) begin
        tx_ready_i = 1'b0;
        frame_start_i = 1'b0;
        chk(frame_cnt_o == fexp, "R6 ignored start", frame_cnt_o, fexp);
        chk(len_valid_o == 1'b0, "R6 no strobe", len_valid_o, 0);
      end else begin
        tx_ready_i = (rmode == 0) ? 1'b1 : (((step * 7 + int'(fexp)) % 5) != 0);
      end
      #1;
      chk(tx_valid_o == 1'b1, "R8 valid", tx_valid_o, 1);
      // R1 R3 R9: byte order and hold under stall
      chk(tx_data_o == e_bytes[k], "R1 byte", tx_data_o, e_bytes[k]);
      chk(tx_last_o == (k == e_len - 1), "R8 last", tx_last_o, k == e_len - 1);
      if (tx_ready_i) k++;
      step++;
      @(negedge clk_i);
    end
    tx_ready_i = 1'b0;
    chk(tx_valid_o == 1'b0, "R8 frame end", tx_valid_o, 0);
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin b_len[s] = 0; b_mask[s] = '0; end
    repeat (3) @(negedge clk_i);
    // reset state (R6 R7 R10)
    chk(tx_valid_o == 1'b0, "R10 reset valid", tx_valid_o, 0);
    chk(frame_cnt_o == 0, "R6 reset count", frame_cnt_o, 0);
    chk(overflow_o == 1'b0, "R5 reset flag", overflow_o, 0);
    chk(len_valid_o == 1'b0, "R7 reset strobe", len_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // reset contents are all zero: empty frame (R10 R7)
    do_frame(0, 1'b0);

    // example pattern, plus R4 length-0 and zero-mask slots
    config_slot(0, 8, 32'hFFFF_FFFF);
    config_slot(1, 4, 32'h5555_5555);
    config_slot(2, 5, 32'hAAAA_AAAA);
    config_slot(3, 6, 32'h1111_1111);
    config_slot(4, 0, 32'hFFFF_FFFF);
    config_slot(5, 3, 32'h0000_0000);
    for (int f = 0; f < 64; f++) begin
      // R2: frame 3 of the phase carries slots 0, 1 and 3
      if (fexp % 32 == 3) begin
        model(fexp);
        chk(e_len == 21, "R2 model frame 3", e_len, 21);
      end
      do_frame(f % 2, 1'b0);
    end

    // R5: slot 2 skipped, slot 3 still fits, total 32
    config_slot(0, 15, 32'hFFFF_FFFF);
    config_slot(1, 12, 32'hFFFF_FFFF);
    config_slot(2, 5, 32'hFFFF_FFFF);
    config_slot(3, 2, 32'hFFFF_FFFF);
    config_slot(4, 0, 32'h0);
    for (int f = 0; f < 4; f++) do_frame(f % 2, 1'b0);
    chk(e_len == 32, "R5 exact fill", e_len, 32);

    // R7 empty frames, flag clears (R5)
    for (int s = 0; s < NS; s++) wr(1, s, 0, 32'h0);
    for (int s = 0; s < NS; s++) b_mask[s] = '0;
    do_frame(0, 1'b0);
    do_frame(0, 1'b0);

    // R6: start during a stalled frame
    config_slot(0, 3, 32'hFFFF_FFFF);
    config_slot(2, 2, 32'hFFFF_FFFF);
    do_frame(1, 1'b1);
    do_frame(0, 1'b0);

    repeat (4) @(negedge clk_i);
    finish_run();
  end
endmodule